// File: doc/BRIEF.md
# Banked Register Memory with Write-Address Overrides

This block holds a 256-word by 16-bit register memory addressed in banks of sixteen. A 4-bit bank base register supplies the upper half of every word address, and the 4-bit register select carried by the current instruction supplies the lower half. Reading is combinational. A write takes effect on the rising clock edge.

By default, an instruction writes its result back to the same word it reads. A 4-bit function-field value can change that write address for one instruction only, in one of two ways:

- **Select override:** the field value replaces the register select for the write. The bank stays the same.
- **Bank override:** the field value replaces the bank for the write. The register select stays the same.

Neither override touches the bank base register. That register is loaded from an immediate value. If an instruction asserts both overrides, the select override is used.

Top module: `bankreg_file`

## Requirements
- R1: The read word address is bank_base * 16 + rd_sel, and rd_data shows that word combinationally.
- R2: Each word stores 16 bits exactly. The patterns 0x0000, 0xFFFF, 0x5555, 0xAAAA and 0x8000 each read back unchanged.
- R3: With wr_en high and no override, wr_data is written at the clock edge to the word being read, {bank_base, rd_sel}.
- R4: With sel_ovr high, the write goes to {bank_base, ovr_val}. The word {bank_base, rd_sel} keeps its value unless the two addresses are equal.
- R5: With bank_ovr high, the write goes to {ovr_val, rd_sel}. The word in the current bank keeps its value unless the two addresses are equal.
- R6: Every bit of both override paths works on its own. This is shown with override values 0, 1, 2, 4 and 8.
- R7: bank_base resets to 0. When base_load is high, bank_base loads base_imm at the clock edge, and later reads use the new bank.
- R8: An override changes only the write address of that cycle. bank_base stays unchanged across a write with either override.
- R9: During a write cycle, a read of the written address returns the old value. The new value appears after the edge.
- R10: When sel_ovr and bank_ovr are both high, the select override is used and the word {ovr_val, rd_sel} is not written.
- R11: With wr_en low, no word changes, whatever the override inputs and wr_data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the bank base |
| base_load | input | 1 | Load bank_base from base_imm |
| base_imm | input | 4 | Immediate bank value |
| rd_sel | input | 4 | Register select from the instruction |
| sel_ovr | input | 1 | Replace the write select with ovr_val |
| bank_ovr | input | 1 | Replace the write bank with ovr_val |
| ovr_val | input | 4 | Function-field override value |
| wr_en | input | 1 | Write enable |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for {bank_base, rd_sel} |
| bank_base | output | 4 | Current bank base register |

## Verification
The hardest case to reach is a write that lands outside the bank being read. The bench can only observe that word after it reloads the bank base and reads the word back.

To make this possible, the bench first fills all 256 words with address-derived values. Each override case then has a known background, so the bench can confirm two things:
- the target word changed;
- the source word, and the word the losing override would have hit, did not.

For the read-during-write case, the bench keeps the read address equal to the write address and samples rd_data both inside the write cycle and after the edge.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   // which address fields the write takes from the override value
   typedef enum logic [1:0] {
      ROUTE_DIRECT = 2'd0,
      ROUTE_SEL    = 2'd1,
      ROUTE_BANK   = 2'd2
   } wr_route_e;

endpackage

// File: rtl/bankreg_base.sv
module bankreg_base #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] imm,
   output logic [BANK_W-1:0] base
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base <= '0;
      else if (load)
         base <= imm;
   end

   // R8: only an explicit load moves the bank base
   assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(base));

   // R7: a load takes the immediate value
   assert_base_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> base == $past(imm));

endmodule

// File: rtl/bankreg_addr.sv
module bankreg_addr
   import bankreg_pkg::*;
#(
   parameter int BANK_W   = 4,
   parameter int SEL_W    = 4,
   parameter bit SEL_WINS = 1'b1,
   localparam int ADDR_W  = BANK_W + SEL_W
) (
   input  logic [BANK_W-1:0] base,
   input  logic [SEL_W-1:0]  sel,
   input  logic              sel_ovr,
   input  logic              bank_ovr,
   input  logic [SEL_W-1:0]  ovr_val,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output wr_route_e         route
);

   assign rd_addr = {base, sel};

   // priority between the two overrides is picked at elaboration
   generate
      if (SEL_WINS) begin : g_sel_first
         always_comb begin
            if (sel_ovr)       route = ROUTE_SEL;
            else if (bank_ovr) route = ROUTE_BANK;
            else               route = ROUTE_DIRECT;
         end
      end else begin : g_bank_first
         always_comb begin
            if (bank_ovr)      route = ROUTE_BANK;
            else if (sel_ovr)  route = ROUTE_SEL;
            else               route = ROUTE_DIRECT;
         end
      end
   endgenerate

   always_comb begin
      unique case (route)
         ROUTE_SEL:  wr_addr = {base, ovr_val};
         ROUTE_BANK: wr_addr = {ovr_val[BANK_W-1:0], sel};
         default:    wr_addr = {base, sel};
      endcase
   end

endmodule

// File: rtl/bankreg_mem.sv
module bankreg_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         words[wr_addr] <= wr_data;
   end

   assign rd_data = words[rd_addr];

   // R9: written data is visible from the cycle after the edge
   assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> words[$past(wr_addr)] == $past(wr_data));

   // R11: without a write the addressed word holds
   assert_no_write_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> words[$past(rd_addr)] == $past(rd_data));

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int BANK_W   = 4,
   parameter int SEL_W    = 4,
   parameter bit SEL_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_load,
   input  logic [BANK_W-1:0] base_imm,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              sel_ovr,
   input  logic              bank_ovr,
   input  logic [SEL_W-1:0]  ovr_val,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [BANK_W-1:0] bank_base
);

   localparam int ADDR_W = BANK_W + SEL_W;

   generate
      if (DATA_W < 1)       begin : g_bad_data  $error("DATA_W must be positive"); end
      if (BANK_W != SEL_W)  begin : g_bad_field $error("override field serves both bank and select: widths must match"); end
      if (ADDR_W > 12)      begin : g_bad_depth $error("memory depth too large"); end
   endgenerate

   logic [ADDR_W-1:0] rd_addr, wr_addr;
   wr_route_e         route;

   bankreg_base #(.BANK_W(BANK_W)) u_base (
      .clk(clk), .rst_n(rst_n), .load(base_load), .imm(base_imm), .base(bank_base)
   );

   bankreg_addr #(.BANK_W(BANK_W), .SEL_W(SEL_W), .SEL_WINS(SEL_WINS)) u_addr (
      .base(bank_base), .sel(rd_sel), .sel_ovr(sel_ovr), .bank_ovr(bank_ovr),
      .ovr_val(ovr_val), .rd_addr(rd_addr), .wr_addr(wr_addr), .route(route)
   );

   bankreg_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // R3: no override writes where it reads
   assert_route_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ovr && !bank_ovr) |-> wr_addr == rd_addr);

   // R4: select override keeps the bank of the read
   assert_route_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ovr |-> (wr_addr[ADDR_W-1:SEL_W] == rd_addr[ADDR_W-1:SEL_W]
                   && wr_addr[SEL_W-1:0] == ovr_val));

   // R5: bank override keeps the select of the read
   assert_route_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_ovr && !sel_ovr) |-> (wr_addr[SEL_W-1:0] == rd_addr[SEL_W-1:0]
                   && wr_addr[ADDR_W-1:SEL_W] == ovr_val));

   // R10: with both asserted the select override governs
   assert_route_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ovr && bank_ovr && SEL_WINS) |-> route == ROUTE_SEL);

endmodule

// File: tb/bankreg_file_tb.sv
module bankreg_file_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_load = 1'b0;
   logic [3:0]  base_imm = '0;
   logic [3:0]  rd_sel = '0;
   logic        sel_ovr = 1'b0;
   logic        bank_ovr = 1'b0;
   logic [3:0]  ovr_val = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [3:0]  bank_base;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] model [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   bankreg_file u_dut (
      .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_imm(base_imm),
      .rd_sel(rd_sel), .sel_ovr(sel_ovr), .bank_ovr(bank_ovr), .ovr_val(ovr_val),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .bank_base(bank_base)
   );

   // vector: {mode[1:0], bank, select, override, data}; mode bit0 = sel_ovr, bit1 = bank_ovr
   localparam logic [29:0] VEC [16] = '{
      {2'd0, 4'h3, 4'h5, 4'h0, 16'h0000},
      {2'd0, 4'h3, 4'h6, 4'h0, 16'hFFFF},
      {2'd0, 4'h3, 4'h7, 4'h0, 16'h5555},
      {2'd0, 4'h3, 4'h8, 4'h0, 16'hAAAA},
      {2'd0, 4'h3, 4'h9, 4'h0, 16'h8000},
      {2'd1, 4'h6, 4'h2, 4'h0, 16'hA001},
      {2'd1, 4'h6, 4'h2, 4'h1, 16'hA002},
      {2'd1, 4'h6, 4'h2, 4'h2, 16'hA003},
      {2'd1, 4'h6, 4'h2, 4'h4, 16'hA004},
      {2'd1, 4'h6, 4'h2, 4'h8, 16'hA005},
      {2'd2, 4'hA, 4'h4, 4'h0, 16'hB001},
      {2'd2, 4'hA, 4'h4, 4'h1, 16'hB002},
      {2'd2, 4'hA, 4'h4, 4'h2, 16'hB003},
      {2'd2, 4'hA, 4'h4, 4'h4, 16'hB004},
      {2'd2, 4'hA, 4'h4, 4'h8, 16'hB005},
      {2'd3, 4'h5, 4'hC, 4'h3, 16'hC0DE}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_base(input logic [3:0] b);
      @(negedge clk);
      base_load = 1'b1;
      base_imm  = b;
      @(negedge clk);
      base_load = 1'b0;
   endtask

   task automatic wr(input logic [3:0] b, input logic [3:0] s, input logic [1:0] m,
                     input logic [3:0] o, input logic [15:0] d);
      logic [7:0] dest;
      set_base(b);
      rd_sel   = s;
      sel_ovr  = m[0];
      bank_ovr = m[1];
      ovr_val  = o;
      wr_data  = d;
      wr_en    = 1'b1;
      @(negedge clk);
      wr_en    = 1'b0;
      sel_ovr  = 1'b0;
      bank_ovr = 1'b0;
      if (m[0])      dest = {b, o};
      else if (m[1]) dest = {o, s};
      else           dest = {b, s};
      model[dest] = d;
   endtask

   task automatic rd_chk(input logic [7:0] a, input string tag);
      set_base(a[7:4]);
      rd_sel = a[3:0];
      #1;
      chk(tag, rd_data, model[a]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R7 reset base", {12'h0, bank_base}, 16'h0000);
      rst_n = 1'b1;

      // background: every word gets an address-derived value
      for (int a = 0; a < 256; a++)
         wr(a[7:4], a[3:0], 2'd0, 4'h0, 16'(a * 16'h0101) ^ 16'h3C5A);
      for (int a = 0; a < 256; a++)
         rd_chk(a[7:0], "R1 address formation");

      // vector table
      for (int i = 0; i < 16; i++) begin
         logic [1:0] m;
         logic [3:0] b, s, o;
         logic [15:0] d;
         string tag;
         {m, b, s, o, d} = VEC[i];
         case (m)
            2'd0:    tag = "R2 R3 pattern";
            2'd1:    tag = "R4 R6 select override";
            2'd2:    tag = "R5 R6 bank override";
            default: tag = "R10 both overrides";
         endcase
         wr(b, s, m, o, d);
         #1;
         chk("R8 base after override", {12'h0, bank_base}, {12'h0, b});
         if (m[0])      rd_chk({b, o}, tag);
         else if (m[1]) rd_chk({o, s}, tag);
         else           rd_chk({b, s}, tag);
         rd_chk({b, s}, tag);
         if (m == 2'd3) rd_chk({o, s}, "R10 losing target untouched");
      end

      // R9: read of the address being written shows old data in that cycle
      set_base(4'h2);
      rd_sel  = 4'h7;
      wr_data = 16'hBEEF;
      wr_en   = 1'b1;
      #1;
      chk("R9 old value during write", rd_data, model[8'h27]);
      @(negedge clk);
      wr_en = 1'b0;
      model[8'h27] = 16'hBEEF;
      #1;
      chk("R9 new value after edge", rd_data, 16'hBEEF);

      // R11: overrides and data without wr_en change nothing
      @(negedge clk);
      wr_data  = 16'h1111;
      sel_ovr  = 1'b1;
      bank_ovr = 1'b1;
      ovr_val  = 4'h7;
      rd_sel   = 4'h7;
      @(negedge clk);
      sel_ovr  = 1'b0;
      bank_ovr = 1'b0;
      #1;
      chk("R11 no write when disabled", rd_data, 16'hBEEF);
      rd_chk(8'h77, "R11 bank target untouched");

      // R7: loaded bank steers subsequent reads
      set_base(4'h9);
      rd_sel = 4'h3;
      #1;
      chk("R7 base value", {12'h0, bank_base}, 16'h0009);
      chk("R7 read from new bank", rd_data, model[8'h93]);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule